// File: doc/BRIEF.md
# Morse Letter Decoder

This block turns a stream of keyed Morse symbols into printable characters. Two level inputs carry the dot and dash keys. Each rising edge on either key moves a short decode tree by one step. The tree recognises every letter made of one or two symbols.

An internal gap timer measures how long both keys have stayed released. When the silence reaches letter length, the decoded letter is presented once on an 8-bit ASCII bus and a 7-bit segment bus, with a one-clock valid strobe. When the silence grows to word length, a single space character follows, again with one strobe.

A third symbol inside one letter leaves the tree. The block then raises an error flag, and at the letter gap it emits a placeholder character with a blank segment pattern. The whole block sits in one clock domain and uses a synchronous, active-high reset.

Top module: `morse_decoder`

## Requirements
- R1: A key level that is held for any number of cycles advances the tree only once, because each rising edge becomes exactly one internal one-clock pulse. A dot held for 40 cycles followed by a word gap yields 'E' and not 'I'.
- R2: From the start state, a dash decodes to 'T' (0x54, segments 7'b1111000) and a dot decodes to 'E' (0x45, segments 7'b1111001). If both keys rise in the same cycle, the dash wins. Segment bits are ordered g,f,e,d,c,b,a from MSB to LSB, active high.
- R3: After 'T', a dash gives 'M' (0x4D, 7'b0010101) and a dot gives 'N' (0x4E, 7'b1010100). After 'E', a dash gives 'A' (0x41, 7'b1110111) and a dot gives 'I' (0x49, 7'b0000110).
- R4: At the letter gap, the current letter's ASCII and segment codes appear on the outputs together with `char_valid`, which is high for exactly one clock. The tree then returns to its start state.
- R5: At the word gap, `char_ascii` is 0x20, `char_seg` is 7'b0000000, and `char_valid` is high for exactly one clock.
- R6: A third symbol within one letter sets `err_flag`. At the following letter gap the block emits ASCII 0x3F with the blank segment pattern 7'b0000000 while `err_flag` is still high, and the tree returns to its start state. The flag clears on the first symbol of the next letter.
- R7: The gap counter restarts on every symbol pulse and counts only while both keys are low. The letter event fires once as the count enters the window above 15 and up to 30. The word event fires once as the count enters the window above 30 and below 50. At 50 the counter clears and stays idle until the next symbol. Silences of 12 cycles or fewer between symbols emit nothing. A silence of 25 cycles emits only the letter. A silence of 45 or 150 cycles emits exactly the letter and one space.
- R8: While reset is high, and right after it, `char_ascii`, `char_seg`, `char_valid` and `err_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_key | input | 1 | Dot key level |
| dash_key | input | 1 | Dash key level |
| char_ascii | output | 8 | ASCII code of the emitted character |
| char_seg | output | 7 | Segment pattern of the emitted character, g..a |
| char_valid | output | 1 | One-clock strobe for each emitted character |
| err_flag | output | 1 | Set when a letter leaves the decode tree |

## Verification
The hardest case to reach from the ports is a long silence that runs past the counter's clear point. Emitting exactly one letter and one space there depends on the timer disarming itself rather than wrapping around and firing again.

The stimulus drives directed silences of 25, 45 and 150 cycles. It then mixes in random letters of one to three symbols, with random hold lengths and random short and long gaps. Every strobe is captured and compared against the letter sequence computed by the bench.

A held key and a same-cycle dot and dash are added as directed cases.

// File: rtl/morse_pkg.sv
package morse_pkg;

    typedef enum logic [2:0] {
        ST_ROOT = 3'd0,
        ST_E    = 3'd1,
        ST_T    = 3'd2,
        ST_A    = 3'd3,
        ST_I    = 3'd4,
        ST_M    = 3'd5,
        ST_N    = 3'd6,
        ST_BAD  = 3'd7
    } tree_st_t;

    typedef struct packed {
        logic [7:0] ascii;
        logic [6:0] seg;
    } glyph_t;

    localparam logic [7:0] ASCII_SPACE = 8'h20;
    localparam logic [7:0] ASCII_UNK   = 8'h3F;
    localparam logic [6:0] SEG_BLANK   = 7'b0000000;

    // Symbol index into the key vector
    localparam int SYM_DOT  = 0;
    localparam int SYM_DASH = 1;
    localparam int NSYM     = 2;

    // One step of the decode tree; dash takes priority over dot
    function automatic tree_st_t tree_step(tree_st_t cur, logic dot, logic dash);
        tree_st_t nx;
        nx = cur;
        if (dot || dash) begin
            case (cur)
                ST_ROOT: nx = dash ? ST_T : ST_E;
                ST_T:    nx = dash ? ST_M : ST_N;
                ST_E:    nx = dash ? ST_A : ST_I;
                default: nx = ST_BAD;
            endcase
        end
        return nx;
    endfunction

    function automatic glyph_t glyph_of(tree_st_t st);
        glyph_t g;
        case (st)
            ST_E:    g = '{ascii: 8'h45, seg: 7'b1111001};
            ST_T:    g = '{ascii: 8'h54, seg: 7'b1111000};
            ST_A:    g = '{ascii: 8'h41, seg: 7'b1110111};
            ST_I:    g = '{ascii: 8'h49, seg: 7'b0000110};
            ST_M:    g = '{ascii: 8'h4D, seg: 7'b0010101};
            ST_N:    g = '{ascii: 8'h4E, seg: 7'b1010100};
            default: g = '{ascii: ASCII_UNK, seg: SEG_BLANK};
        endcase
        return g;
    endfunction

endpackage

// File: rtl/morse_edge_det.sv
module morse_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] pulse
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_sym
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                pulse[i]  <= 1'b0;
            end else begin
                prev_q[i] <= lvl[i];
                pulse[i]  <= lvl[i] & ~prev_q[i];
            end
        end

        // R1: a pulse lasts one clock, and only follows a sampled high level
        p_pulse_single_r1: assert property (@(posedge clk) disable iff (rst)
            pulse[i] |=> !pulse[i]);
        p_pulse_from_level_r1: assert property (@(posedge clk) disable iff (rst)
            pulse[i] |-> $past(lvl[i]));
    end

endmodule

// File: rtl/morse_gap_timer.sv
module morse_gap_timer #(
    parameter int THREE_LO = 15,
    parameter int THREE_HI = 30,
    parameter int SEVEN_HI = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_pulse,
    input  logic keys_idle,
    output logic three_evt,
    output logic seven_evt
);

    localparam int CW = $clog2(SEVEN_HI + 1);
    localparam logic [CW-1:0] C_THREE_LO = CW'(THREE_LO);
    localparam logic [CW-1:0] C_THREE_HI = CW'(THREE_HI);
    localparam logic [CW-1:0] C_SEVEN_HI = CW'(SEVEN_HI);

    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          three_win, seven_win;
    logic          three_win_q, seven_win_q;

    assign three_win = (cnt_q > C_THREE_LO) && (cnt_q <= C_THREE_HI);
    assign seven_win = (cnt_q > C_THREE_HI) && (cnt_q <  C_SEVEN_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (sym_pulse) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (armed_q && keys_idle) begin
            if (cnt_q == C_SEVEN_HI) begin
                cnt_q   <= '0;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            three_win_q <= 1'b0;
            seven_win_q <= 1'b0;
        end else begin
            three_win_q <= three_win;
            seven_win_q <= seven_win;
        end
    end

    assign three_evt = three_win & ~three_win_q;
    assign seven_evt = seven_win & ~seven_win_q;

    // R7: the count stays within its limit, holds when idle, and events are single
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= C_SEVEN_HI);
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!armed_q && !sym_pulse) |=> (cnt_q == '0));
    p_three_once_r7: assert property (@(posedge clk) disable iff (rst)
        three_evt |=> !three_evt);
    p_events_apart_r7: assert property (@(posedge clk) disable iff (rst)
        !(three_evt && seven_evt));

endmodule

// File: rtl/morse_tree.sv
module morse_tree
    import morse_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       dot_p,
    input  logic       dash_p,
    input  logic       three_evt,
    input  logic       seven_evt,
    output logic [7:0] char_ascii,
    output logic [6:0] char_seg,
    output logic       char_valid,
    output logic       err_flag
);

    tree_st_t state_q, base_st, next_st;
    glyph_t   cur_glyph;
    logic     sym;

    assign sym       = dot_p | dash_p;
    assign cur_glyph = glyph_of(state_q);

    // A letter gap closes the current letter, so a symbol in that same cycle starts from the root
    always_comb begin
        base_st = three_evt ? ST_ROOT : state_q;
        next_st = tree_step(base_st, dot_p, dash_p);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_ROOT;
            char_ascii <= '0;
            char_seg   <= '0;
            char_valid <= 1'b0;
            err_flag   <= 1'b0;
        end else begin
            state_q    <= next_st;
            char_valid <= 1'b0;
            if (three_evt && state_q != ST_ROOT) begin
                char_valid <= 1'b1;
                char_ascii <= cur_glyph.ascii;
                char_seg   <= cur_glyph.seg;
            end else if (seven_evt) begin
                char_valid <= 1'b1;
                char_ascii <= ASCII_SPACE;
                char_seg   <= SEG_BLANK;
            end
            if (next_st == ST_BAD)
                err_flag <= 1'b1;
            else if (sym && base_st == ST_ROOT)
                err_flag <= 1'b0;
        end
    end

    // R4: single-cycle strobe; the tree is back at its root after a letter gap without a symbol
    p_strobe_width_r4: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);
    p_root_after_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (three_evt && !sym) |=> (state_q == ST_ROOT));
    // R5: a word gap produces the space code
    p_space_out_r5: assert property (@(posedge clk) disable iff (rst)
        seven_evt |=> (char_valid && char_ascii == ASCII_SPACE && char_seg == SEG_BLANK));
    // R6: an out-of-tree letter is always shown blank
    p_blank_on_err_r6: assert property (@(posedge clk) disable iff (rst)
        (char_valid && err_flag) |-> (char_seg == SEG_BLANK));
    p_err_on_bad_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BAD) |-> err_flag);

endmodule

// File: rtl/morse_decoder.sv
module morse_decoder #(
    parameter int THREE_LO = 15,
    parameter int THREE_HI = 30,
    parameter int SEVEN_HI = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dot_key,
    input  logic       dash_key,
    output logic [7:0] char_ascii,
    output logic [6:0] char_seg,
    output logic       char_valid,
    output logic       err_flag
);

    import morse_pkg::*;

    logic [NSYM-1:0] keys;
    logic [NSYM-1:0] pulses;
    logic            three_evt, seven_evt;

    assign keys[SYM_DOT]  = dot_key;
    assign keys[SYM_DASH] = dash_key;

    morse_edge_det #(.N(NSYM)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl   (keys),
        .pulse (pulses)
    );

    morse_gap_timer #(
        .THREE_LO (THREE_LO),
        .THREE_HI (THREE_HI),
        .SEVEN_HI (SEVEN_HI)
    ) u_gap (
        .clk       (clk),
        .rst       (rst),
        .sym_pulse (|pulses),
        .keys_idle (~|keys),
        .three_evt (three_evt),
        .seven_evt (seven_evt)
    );

    morse_tree u_tree (
        .clk        (clk),
        .rst        (rst),
        .dot_p      (pulses[SYM_DOT]),
        .dash_p     (pulses[SYM_DASH]),
        .three_evt  (three_evt),
        .seven_evt  (seven_evt),
        .char_ascii (char_ascii),
        .char_seg   (char_seg),
        .char_valid (char_valid),
        .err_flag   (err_flag)
    );

    // R8: nothing is emitted in the cycle after reset
    p_quiet_after_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (!char_valid && !err_flag));

endmodule

// File: tb/morse_decoder_tb.sv
module morse_decoder_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       dot_key, dash_key;
    logic [7:0] char_ascii;
    logic [6:0] char_seg;
    logic       char_valid;
    logic       err_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    morse_decoder u_dut (
        .clk        (clk),
        .rst        (rst),
        .dot_key    (dot_key),
        .dash_key   (dash_key),
        .char_ascii (char_ascii),
        .char_seg   (char_seg),
        .char_valid (char_valid),
        .err_flag   (err_flag)
    );

    // capture of strobed characters
    int         cap_n = 0;
    logic [7:0] cap_a [0:15];
    logic [6:0] cap_s [0:15];
    logic       cap_e [0:15];
    logic       prev_valid = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && char_valid) begin
            if (cap_n < 16) begin
                cap_a[cap_n] = char_ascii;
                cap_s[cap_n] = char_seg;
                cap_e[cap_n] = err_flag;
            end
            cap_n++;
            check("R4 strobe width", {31'd0, prev_valid}, 32'd0);
        end
        prev_valid = char_valid;
    end

    // expected decoding; bits[i]=1 means symbol i is a dash
    function automatic logic [7:0] exp_ascii(int len, logic [2:0] bits);
        if (len == 1) return bits[0] ? 8'h54 : 8'h45;
        if (len == 2) begin
            if (bits[0]) return bits[1] ? 8'h4D : 8'h4E;
            return bits[1] ? 8'h41 : 8'h49;
        end
        return 8'h3F;
    endfunction

    function automatic logic [6:0] exp_seg(logic [7:0] a);
        case (a)
            8'h45:   return 7'b1111001;
            8'h54:   return 7'b1111000;
            8'h41:   return 7'b1110111;
            8'h49:   return 7'b0000110;
            8'h4D:   return 7'b0010101;
            8'h4E:   return 7'b1010100;
            default: return 7'b0000000;
        endcase
    endfunction

    function automatic string req_of(int len);
        if (len == 1) return "R2";
        if (len == 2) return "R3";
        return "R6";
    endfunction

    task automatic idle(input int n);
        dot_key  = 1'b0;
        dash_key = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic key(input logic dsh, input int hold);
        dot_key  = ~dsh;
        dash_key = dsh;
        repeat (hold) @(negedge clk);
        dot_key  = 1'b0;
        dash_key = 1'b0;
    endtask

    // send a letter and a final gap, then compare the captured strobes
    task automatic run_letter(input int len, input logic [2:0] bits, input int hold_max,
                              input int final_gap);
        logic [7:0] ea;
        string      rq;
        cap_n = 0;
        for (int i = 0; i < len; i++) begin
            key(bits[i], 1 + ($urandom % hold_max));
            if (i < len - 1) idle(2 + ($urandom % 11));
        end
        idle(final_gap);
        ea = exp_ascii(len, bits);
        rq = req_of(len);
        check({"R7 strobe count ", rq}, cap_n, (final_gap >= 40) ? 2 : 1);
        check({rq, " ascii"}, cap_a[0], ea);
        check({rq, " seg"}, cap_s[0], exp_seg(ea));
        check("R6 err at letter", cap_e[0], (len >= 3) ? 1 : 0);
        if (final_gap >= 40) begin
            check("R5 space ascii", cap_a[1], 8'h20);
            check("R5 space seg", cap_s[1], 7'b0000000);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst      = 1'b1;
        dot_key  = 1'b0;
        dash_key = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 reset ascii", char_ascii, 0);
        check("R8 reset seg", char_seg, 0);
        check("R8 reset valid", char_valid, 0);
        check("R8 reset err", err_flag, 0);
        rst = 1'b0;
        idle(60);
        check("R7 no emit before first symbol", cap_n, 0);

        // directed letters with short, word and very long silences
        run_letter(1, 3'b001, 3, 25);
        run_letter(1, 3'b000, 3, 45);
        run_letter(2, 3'b011, 3, 150);
        run_letter(2, 3'b001, 3, 25);
        run_letter(2, 3'b010, 3, 45);
        run_letter(2, 3'b000, 3, 25);
        run_letter(3, 3'b101, 3, 45);
        check("R6 err still high after bad letter", err_flag, 1);
        run_letter(1, 3'b000, 3, 45);
        check("R6 err cleared by next letter", err_flag, 0);

        // R1: held dot counts once
        cap_n = 0;
        key(1'b0, 40);
        idle(45);
        check("R1 held key count", cap_n, 2);
        check("R1 held key ascii", cap_a[0], 8'h45);

        // R2: both keys rising together decode as dash
        cap_n    = 0;
        dot_key  = 1'b1;
        dash_key = 1'b1;
        repeat (3) @(negedge clk);
        idle(25);
        check("R2 simultaneous keys ascii", cap_a[0], 8'h54);
        check("R2 simultaneous keys count", cap_n, 1);

        // random letters
        for (int n = 0; n < 40; n++) begin
            int         len;
            logic [2:0] b;
            len = 1 + ($urandom % 3);
            b   = 3'($urandom);
            run_letter(len, b, 6, ($urandom % 2) ? 45 : 25);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule